// File: doc/BRIEF.md
# Tagged Multi-Line Receive Queue

This block gathers characters from up to sixteen serial receivers into one shared first-in first-out store. Each receiver delivers a character on a one-cycle strobe together with its parity and framing error indications. The block parks every character in a one-deep holding slot for its line. A fixed-priority picker then moves one held character per clock into the shared store. As it does so, the character is tagged with the number of its line and with its error flags.

Software drains the store one 16-bit word at a time. The current head word is always visible on the read port, and a one-cycle pop strobe advances to the next entry. A word with its top bit clear means the store is empty. A control/status register holds the interrupt enables and shows the two interrupt conditions: store not empty, and fill at or above a programmable alarm level. The same register also accepts a master-clear command. The block drives one combined receive interrupt output.

Top module: `rx_tag_queue`

## Requirements
- R1: The read word is all zero while the store is empty; otherwise bit 15 is 1 and bits 7:0 hold the character at the head of the store.
- R2: Bits 11:8 of a non-empty read word hold the number of the line that delivered the character.
- R3: Bit 12 of a read word is the parity error flag, bit 13 is the framing error flag and bit 14 is the overrun flag, each as delivered with that character.
- R4: Each pop strobe removes exactly one entry, and entries leave in the order they entered. A pop on an empty store has no effect.
- R5: When several lines hold a character, one character per clock enters the store, and the lowest-numbered line goes first. A character strobed at clock edge t can enter the store at edge t+1 at the earliest.
- R6: The store holds DEPTH (64) entries. A character picked while the store is full is discarded, and the next character that is stored carries overrun bit 14.
- R7: If a line strobes a new character while its previous one is still waiting for the picker, the old one is lost and the new one carries overrun bit 14.
- R8: Control bit 6 is the receive interrupt enable (read/write). Control bit 7 reads 1 whenever the store is non-empty. The interrupt output is high when both are 1.
- R9: The alarm level is written with select 1 (value in the low bits). Control bit 14 reads 1 when the store is non-empty and holds at least the alarm level. Bit 12 is its enable, and the interrupt output is also high when bits 12 and 14 are both 1.
- R10: Writing the control register with bit 11 set empties the store, the holding slots and the pending overrun, and clears both enables. On the next cycle the control register and the read word both read zero.
- R11: After reset the read word, the control register and the interrupt output are zero, and the alarm level is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_valid | input | NLINES | Per-line one-cycle character strobe |
| line_data | input | 8*NLINES | Per-line character, line i in bits 8i+7:8i |
| line_perr | input | NLINES | Per-line parity error with the strobe |
| line_ferr | input | NLINES | Per-line framing error (break) with the strobe |
| rd_pop | input | 1 | Pop the head entry |
| rd_data | output | 16 | Head word: valid, overrun, framing, parity, line, character |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects control, 1 selects alarm level |
| wr_data | input | 16 | Register write data |
| csr_rdata | output | 16 | Control/status register contents |
| rx_irq | output | 1 | Combined receive interrupt |

## Verification
Most internal state leaves a trace on the head word within a few clocks. A misdirected pointer or a wrong count makes the read word show a stale or missing character, or a valid bit out of step with the number of pushes and pops. A reference queue compared on every clock catches such a fault on the first read after the fault. Errors in the picker or the holding slots show up as a wrong line field, a swapped order, or a missing overrun flag on the next word from that line. A wrong fill count shows up at once as an alarm bit, and interrupt output, that disagrees with the number of entries held.

// File: rtl/rx_tag_pkg.sv
// Shared types for the tagged multi-line receive queue.
// Assumes a line field of 4 bits and 8-bit characters, fixed by the read word layout.
package rx_tag_pkg;
    localparam int LINE_W = 4;
    localparam int CHAR_W = 8;

    typedef struct packed {
        logic              ovr;
        logic              ferr;
        logic              perr;
        logic [LINE_W-1:0] line;
        logic [CHAR_W-1:0] ch;
    } rx_entry_t;

    localparam int ENTRY_W = $bits(rx_entry_t);
endpackage

// File: rtl/rx_line_slot.sv
// One-deep holding slot for a single receive line.
// Loads on a strobe, empties when granted, and marks overrun when a waiting
// character is overwritten before the picker takes it.
module rx_line_slot
    import rx_tag_pkg::*;
#(
    parameter int LINE_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              strobe,
    input  logic [CHAR_W-1:0] ch_in,
    input  logic              perr_in,
    input  logic              ferr_in,
    input  logic              grant,
    output logic              pending,
    output rx_entry_t         entry
);
    localparam logic [LINE_W-1:0] LINE_TAG = LINE_W'(LINE_ID);

    // Slot state: load on strobe, drop on grant, flush on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pending    <= 1'b0;
            entry.ovr  <= 1'b0;
            entry.ferr <= 1'b0;
            entry.perr <= 1'b0;
            entry.ch   <= '0;
        end else if (strobe) begin
            pending    <= 1'b1;
            entry.ovr  <= pending && !grant;
            entry.ferr <= ferr_in;
            entry.perr <= perr_in;
            entry.ch   <= ch_in;
        end else if (grant) begin
            pending    <= 1'b0;
        end
    end

    assign entry.line = LINE_TAG;

    assert_slot_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !pending);
    assert_slot_overwrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && strobe && pending && !grant) |=> (pending && entry.ovr));
endmodule

// File: rtl/rx_pick.sv
// Fixed-priority picker: grants the lowest-numbered pending line each cycle.
// Purely combinational; assumes the caller clears the granted slot.
module rx_pick #(
    parameter int NLINES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] pending,
    output logic [NLINES-1:0] grant
);
    // Lowest set bit of pending wins.
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int i = 0; i < NLINES; i++) begin
            if (pending[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    assert_pick_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    assert_pick_only_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~pending) == '0);
    assert_pick_progress_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|pending) |-> (|grant));
endmodule

// File: rtl/rx_store.sv
// Circular first-in first-out store for tagged entries.
// Assumes DEPTH is a power of two and that the caller never pushes when full
// or pops when empty. The head entry is visible combinationally.
module rx_store #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 15
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       push,
    input  logic [WIDTH-1:0]           wdata,
    input  logic                       pop,
    output logic [WIDTH-1:0]           head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       empty,
    output logic                       full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;

    // Storage array write.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign head  = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (count == $past(count) + CW'($past(push)) - CW'($past(pop))));
endmodule

// File: rtl/rx_tag_queue.sv
// Tagged multi-line receive queue (top level).
// Collects characters from NLINES receivers through per-line slots and a
// lowest-first picker into a shared store; exposes the head word, a control
// register with master clear, an alarm level and a combined interrupt.
module rx_tag_queue
    import rx_tag_pkg::*;
#(
    parameter int NLINES = 16,
    parameter int DEPTH  = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NLINES-1:0]        line_valid,
    input  logic [CHAR_W*NLINES-1:0] line_data,
    input  logic [NLINES-1:0]        line_perr,
    input  logic [NLINES-1:0]        line_ferr,
    input  logic                     rd_pop,
    output logic [15:0]              rd_data,
    input  logic                     wr_en,
    input  logic                     wr_sel,
    input  logic [15:0]              wr_data,
    output logic [15:0]              csr_rdata,
    output logic                     rx_irq
);
    localparam int CNT_W   = $clog2(DEPTH+1);
    localparam int BIT_RIE = 6;
    localparam int BIT_MC  = 11;
    localparam int BIT_SIE = 12;

    logic [NLINES-1:0] pend;
    logic [NLINES-1:0] grant;
    rx_entry_t         slot_ent [NLINES];
    rx_entry_t         picked;
    rx_entry_t         push_ent;
    rx_entry_t         head;
    logic [CNT_W-1:0]  count;
    logic [CNT_W-1:0]  alarm;
    logic              empty, full, lost, rie, sie;
    logic              mclr, push, pop, any_grant, si, ri;
    logic              unused_wr;

    assign mclr      = wr_en && !wr_sel && wr_data[BIT_MC];
    assign any_grant = |grant;
    assign push      = any_grant && !full && !mclr;
    assign pop       = rd_pop && !empty && !mclr;
    assign unused_wr = ^wr_data;

    for (genvar i = 0; i < NLINES; i++) begin : g_slot
        rx_line_slot #(.LINE_ID(i)) i_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (mclr),
            .strobe  (line_valid[i]),
            .ch_in   (line_data[i*CHAR_W +: CHAR_W]),
            .perr_in (line_perr[i]),
            .ferr_in (line_ferr[i]),
            .grant   (grant[i]),
            .pending (pend[i]),
            .entry   (slot_ent[i])
        );
    end

    rx_pick #(.NLINES(NLINES)) i_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pend),
        .grant   (grant)
    );

    // Route the granted slot's entry toward the store.
    always_comb begin
        picked = '0;
        for (int i = 0; i < NLINES; i++) begin
            if (grant[i]) picked = picked | slot_ent[i];
        end
        push_ent     = picked;
        push_ent.ovr = picked.ovr | lost;
    end

    rx_store #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) i_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (mclr),
        .push  (push),
        .wdata (push_ent),
        .pop   (pop),
        .head  (head),
        .count (count),
        .empty (empty),
        .full  (full)
    );

    // Pending overrun: set by a drop at full, consumed by the next stored entry.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr)         lost <= 1'b0;
        else if (any_grant && full) lost <= 1'b1;
        else if (push)              lost <= 1'b0;
    end

    // Control register enables and alarm level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rie   <= 1'b0;
            sie   <= 1'b0;
            alarm <= '0;
        end else if (mclr) begin
            rie   <= 1'b0;
            sie   <= 1'b0;
        end else if (wr_en && !wr_sel) begin
            rie   <= wr_data[BIT_RIE];
            sie   <= wr_data[BIT_SIE];
        end else if (wr_en && wr_sel) begin
            alarm <= wr_data[CNT_W-1:0];
        end
    end

    assign ri        = !empty;
    assign si        = !empty && (count >= alarm);
    assign rd_data   = empty ? 16'h0000 : {1'b1, head};
    assign csr_rdata = {1'b0, si, 1'b0, sie, 4'b0000, ri, rie, 6'b000000};
    assign rx_irq    = (rie && ri) || (sie && si);

    assert_empty_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[15] |-> (rd_data == 16'h0000));
    assert_mclr_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mclr |=> (csr_rdata == 16'h0000 && rd_data == 16'h0000 && !rx_irq));
    assert_drop_marks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (any_grant && full && !mclr) |=> lost);
    assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> ((csr_rdata[6] && csr_rdata[7]) || (csr_rdata[12] && csr_rdata[14])));
endmodule

// File: tb/test_rx_tag_queue.sv
module test_rx_tag_queue;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 16;
    localparam int DP = 64;
    localparam int WATCHDOG = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] line_valid = '0;
    logic [8*NL-1:0] line_data = '0;
    logic [NL-1:0] line_perr = '0;
    logic [NL-1:0] line_ferr = '0;
    logic          rd_pop = 1'b0;
    logic [15:0]   rd_data;
    logic          wr_en = 1'b0;
    logic          wr_sel = 1'b0;
    logic [15:0]   wr_data = '0;
    logic [15:0]   csr_rdata;
    logic          rx_irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    rx_tag_queue #(.NLINES(NL), .DEPTH(DP)) i_rx_tag_queue (
        .clk(clk), .rst_n(rst_n), .line_valid(line_valid), .line_data(line_data),
        .line_perr(line_perr), .line_ferr(line_ferr), .rd_pop(rd_pop), .rd_data(rd_data),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .csr_rdata(csr_rdata),
        .rx_irq(rx_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference state.
    int m_q[$];
    bit m_pend[NL];
    int m_ent[NL];
    bit m_lost, m_rie, m_sie;
    int m_alarm;

    always @(posedge clk) begin
        int g;
        bit was_full;
        bit mc;
        mc = wr_en && !wr_sel && wr_data[11];
        if (!rst_n || mc) begin
            m_q.delete();
            for (int i = 0; i < NL; i++) begin m_pend[i] = 0; m_ent[i] = 0; end
            m_lost = 0; m_rie = 0; m_sie = 0;
            if (!rst_n) m_alarm = 0;
        end else begin
            g = -1;
            for (int i = NL-1; i >= 0; i--) if (m_pend[i]) g = i;
            was_full = (m_q.size() == DP);
            if (rd_pop && m_q.size() > 0) void'(m_q.pop_front());
            if (g >= 0) begin
                if (!was_full) begin
                    m_q.push_back(m_ent[g] | (m_lost ? 32'h4000 : 0));
                    m_lost = 0;
                end else m_lost = 1;
            end
            for (int i = 0; i < NL; i++) begin
                if (line_valid[i]) begin
                    m_ent[i] = ((m_pend[i] && i != g) ? 32'h4000 : 0) |
                               (line_ferr[i] ? 32'h2000 : 0) | (line_perr[i] ? 32'h1000 : 0) |
                               (i << 8) | int'(line_data[i*8 +: 8]);
                    m_pend[i] = 1;
                end else if (i == g) m_pend[i] = 0;
            end
            if (wr_en && !wr_sel) begin m_rie = wr_data[6]; m_sie = wr_data[12]; end
            if (wr_en && wr_sel) m_alarm = int'(wr_data[6:0]);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare against the reference every clock, away from the active edge.
    always @(negedge clk) begin
        int ew, ec, n;
        bit ri, si;
        if (rst_n && !finished) begin
            n  = m_q.size();
            ew = (n > 0) ? (32'h8000 | m_q[0]) : 0;
            ri = (n > 0);
            si = (n > 0) && (n >= m_alarm);
            ec = (si << 14) | (m_sie << 12) | (ri << 7) | (m_rie << 6);
            chk("R1 valid/char", {rd_data[15], rd_data[7:0]}, {ew[15], ew[7:0]});
            chk("R2 line", rd_data[11:8], ew[11:8]);
            chk("R3 flags", rd_data[14:12], ew[14:12]);
            chk("R8 rie/ri", csr_rdata[7:6], ec[7:6]);
            chk("R9 sie/si", {csr_rdata[14], csr_rdata[12]}, {ec[14], ec[12]});
            chk("R8 R9 irq", rx_irq, (m_rie && ri) || (m_sie && si));
        end
    end

    task automatic strobe(input int mask, input int d0, input int pe, input int fe);
        @(negedge clk);
        for (int i = 0; i < NL; i++) begin
            line_valid[i] = mask[i];
            line_data[i*8 +: 8] = 8'(d0 + i);
        end
        line_perr = NL'(pe);
        line_ferr = NL'(fe);
        @(negedge clk);
        line_valid = '0; line_perr = '0; line_ferr = '0;
    endtask

    task automatic strobe1(input int ln, input int d, input int pe, input int fe);
        @(negedge clk);
        line_valid = '0;
        line_valid[ln] = 1'b1;
        line_data[ln*8 +: 8] = 8'(d);
        line_perr[ln] = pe[0];
        line_ferr[ln] = fe[0];
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        line_valid = '0; line_perr = '0; line_ferr = '0;
        repeat (n) @(negedge clk);
    endtask

    task automatic read_word(output logic [15:0] w);
        @(negedge clk);
        w = rd_data;
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    task automatic write_reg(input logic sel, input logic [15:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin
        logic [15:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset word", rd_data, 0);
        chk("R11 reset csr", csr_rdata, 0);
        chk("R11 reset irq", rx_irq, 0);

        // R2 R3: single character with parity error on line 5.
        strobe1(5, 8'hA5, 1, 0);
        idle(1);
        chk("R2 R3 line5 word", rd_data, 16'h95A5);

        // R5: three lines at once, lowest first; R4 order of reads.
        strobe(32'h008A, 8'h10, 0, 0);
        idle(3);
        read_word(w); chk("R4 first", w, 16'h95A5);
        read_word(w); chk("R5 line1", w, 16'h8111);
        read_word(w); chk("R5 line3", w, 16'h8313);
        read_word(w); chk("R5 line7", w, 16'h8717);
        read_word(w); chk("R1 empty", w, 16'h0000);
        read_word(w); chk("R4 pop on empty", w, 16'h0000);

        // R7: line 2 overwritten while waiting behind lines 0 and 1.
        @(negedge clk);
        line_valid = 16'h0007;
        line_data[7:0] = 8'h01; line_data[15:8] = 8'h02; line_data[23:16] = 8'h22;
        line_ferr = 16'h0002;
        @(negedge clk);
        line_valid = 16'h0004; line_data[23:16] = 8'h2B; line_ferr = '0;
        idle(4);
        read_word(w); chk("R7 line0", w, 16'h8001);
        read_word(w); chk("R3 framing", w, 16'hA102);
        read_word(w); chk("R7 overrun", w, 16'hC22B);

        // R6: overfill from line 9, then the next stored entry carries overrun.
        for (int i = 0; i < DP + 2; i++) strobe1(9, i, 0, 0);
        idle(3);
        chk("R6 head", rd_data, 16'h8900);
        read_word(w);
        strobe1(9, 8'hEE, 0, 0);
        idle(3);
        for (int i = 1; i < DP; i++) begin
            read_word(w);
            chk("R6 kept", w, 16'h8900 | i);
        end
        read_word(w); chk("R6 overrun after drop", w, 16'hC9EE);
        read_word(w); chk("R6 drained", w, 16'h0000);

        // R8 R9: enables and alarm level.
        write_reg(1'b1, 16'd3);
        write_reg(1'b0, 16'h0040);
        chk("R8 irq idle", rx_irq, 0);
        strobe(32'h0070, 8'h40, 0, 0);
        idle(1);
        chk("R8 irq on data", rx_irq, 1);
        write_reg(1'b0, 16'h1000);
        idle(2);
        chk("R9 alarm csr", csr_rdata, 16'h5080);
        chk("R9 alarm irq", rx_irq, 1);
        read_word(w);
        chk("R9 below alarm", csr_rdata, 16'h1080);
        chk("R9 irq off", rx_irq, 0);

        // R10: master clear with slots pending.
        write_reg(1'b0, 16'h1040);
        @(negedge clk);
        line_valid = 16'h1C00;
        @(negedge clk);
        line_valid = '0;
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 16'h0800;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        chk("R10 csr", csr_rdata, 0);
        chk("R10 word", rd_data, 0);
        idle(3);
        chk("R10 slots flushed", rd_data, 0);

        idle(2);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule